// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipeline. A horizontal counter steps once per clock, and each clock stands for two pixels. A vertical counter steps in half-lines. It advances once at the half-line point of each line and once at the line wrap, so one full line is two vertical counts. Compare points held in registers turn these counters into horizontal and vertical sync, a data-enable for active video, a vertical window that is slightly wider than the active region, and a prefetch pulse that tells a pixel fetcher a line of memory is about to be needed.

A frame-buffer start address is computed from a pan position, a line pitch and a colour-depth code, and rounded down to a 32-byte boundary. The new value is held back until the vertical counter enters blanking, so a change of pan never tears a visible frame. A control register gates each sync separately and can force the picture blank while the counters keep running. Configuration goes through a plain write strobe with an address and a data word. The block has no streaming interface, so there is no back-pressure.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 to H_TOTAL+1 and then wraps, so a line lasts H_TOTAL+2 clocks. If the counter is already past that limit, it wraps on the next clock.
- R2: `hsync` is high while the horizontal count is at or above H_SYNC_ON, or below H_SYNC_OFF. The active span therefore runs through the wrap.
- R3: The vertical counter steps at the clock that leaves horizontal count H_HALF and at the clock that leaves the line wrap. It wraps to 0 after count V_TOTAL-1, so a frame is V_TOTAL/2 lines. `vsync` is high while the vertical count is at or above V_SYNC_ON, or below V_SYNC_OFF.
- R4: `de` is high when the horizontal count lies in [H_BLANK_OFF, H_BLANK_ON) and the vertical count lies in [V_BLANK_OFF, V_BLANK_ON).
- R5: `vwin` is high while the vertical count lies in [V_WIN_START, V_WIN_STOP).
- R6: `fetch_go` pulses for one clock when the horizontal count equals H_FETCH and the vertical count is inside the active range of R4.
- R7: Control bit 10 forces blanking. While it is set, `de` stays low and the syncs and counters keep running.
- R8: `vsync` can go high only while control bits 1 and 0 are both set. If either bit is clear, `vsync` stays low.
- R9: `hsync` can go high only while control bits 5 and 4 are both set. If either bit is clear, `hsync` stays low.
- R10: The pending start address is Y*PITCH + (X << DEPTH), truncated to the address width, with its low 5 bits cleared. DEPTH is 0, 1 or 2 for 1, 2 or 4 bytes per pixel.
- R11: `fb_start` takes the pending value only on the clock where the vertical counter steps into V_BLANK_ON. Writes made during active video leave `fb_start` unchanged until then.
- R12: The register map is: addresses 0 to 15 are V_WIN_STOP, V_BLANK_ON, V_BLANK_OFF, V_WIN_START, V_SYNC_OFF, V_SYNC_ON, V_TOTAL, H_FETCH, H_TOTAL, H_BLANK_ON, H_BLANK_OFF, H_SYNC_OFF, H_SYNC_ON, H_EQUAL, H_HALF and H_SERRATE, in that order, with values in bits 11:0. Address 16 is control, 17 is pitch (bits 23:0), 18 is pan (X in bits 15:0, Y in bits 31:16), and 19 is depth (bits 1:0). Writes to H_EQUAL (13), H_SERRATE (15) or addresses 20 and above change no output.
- R13: After reset, all registers are zero and `hsync`, `vsync`, `de`, `vwin`, `fetch_go` and `fb_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per two pixels |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video enable |
| vwin | output | 1 | Vertical window |
| fetch_go | output | 1 | Line prefetch pulse |
| fb_start | output | AW (24) | Frame-buffer start address |

## Verification
The bench counts each output over exactly one frame. It then measures line and frame periods between sync edges, in two modes whose lines differ in length. This exposes off-by-one errors in the wrap limits, and any step at the half-line point that is in the wrong place: the vertical window then comes out a few clocks too long or too short. A pan update is written during active video and must not appear until blanking; a design without the double buffer changes `fb_start` in mid-frame. Partly set sync-enable pairs must keep a sync quiet, and the bench checks that a decoder which tests only one bit lets that sync through. Forced blanking must not stop vertical sync, and writes to the two unused timing slots must not move any count.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int CFG_AW = 5;
  localparam int CFG_DW = 32;

  // register slots; the 0..15 order is the one software programs by index
  typedef enum logic [CFG_AW-1:0] {
    A_V_WIN_STOP  = 5'd0,
    A_V_BLANK_ON  = 5'd1,
    A_V_BLANK_OFF = 5'd2,
    A_V_WIN_START = 5'd3,
    A_V_SYNC_OFF  = 5'd4,
    A_V_SYNC_ON   = 5'd5,
    A_V_TOTAL     = 5'd6,
    A_H_FETCH     = 5'd7,
    A_H_TOTAL     = 5'd8,
    A_H_BLANK_ON  = 5'd9,
    A_H_BLANK_OFF = 5'd10,
    A_H_SYNC_OFF  = 5'd11,
    A_H_SYNC_ON   = 5'd12,
    A_H_EQUAL     = 5'd13,
    A_H_HALF      = 5'd14,
    A_H_SERRATE   = 5'd15,
    A_CTRL        = 5'd16,
    A_PITCH       = 5'd17,
    A_PAN         = 5'd18,
    A_DEPTH       = 5'd19
  } cfg_addr_e;

  localparam int BLANK_BIT = 10;
  localparam int VS_EN_LO  = 0;
  localparam int HS_EN_LO  = 4;

  typedef struct packed {
    logic force_blank;
    logic vs_en;
    logic hs_en;
  } ctrl_t;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW    = 12,
  parameter int AW    = 24,
  parameter int ALIGN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              blank_go,
  output logic [CW-1:0]     v_win_stop,
  output logic [CW-1:0]     v_blank_on,
  output logic [CW-1:0]     v_blank_off,
  output logic [CW-1:0]     v_win_start,
  output logic [CW-1:0]     v_sync_off,
  output logic [CW-1:0]     v_sync_on,
  output logic [CW-1:0]     v_total,
  output logic [CW-1:0]     h_fetch,
  output logic [CW-1:0]     h_total,
  output logic [CW-1:0]     h_blank_on,
  output logic [CW-1:0]     h_blank_off,
  output logic [CW-1:0]     h_sync_off,
  output logic [CW-1:0]     h_sync_on,
  output logic [CW-1:0]     h_half,
  output ctrl_t             ctrl,
  output logic [AW-1:0]     fb_start
);

  localparam int PW = AW + 16;

  logic [CW-1:0] d;
  logic [15:0]   pan_x, pan_y;
  logic [1:0]    depth;
  logic [AW-1:0] pitch;

  assign d = wdata[CW-1:0];
  wire unused_wdata = &{1'b0, wdata[CFG_DW-1:CW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_win_stop  <= '0;
      v_blank_on  <= '0;
      v_blank_off <= '0;
      v_win_start <= '0;
      v_sync_off  <= '0;
      v_sync_on   <= '0;
      v_total     <= '0;
      h_fetch     <= '0;
      h_total     <= '0;
      h_blank_on  <= '0;
      h_blank_off <= '0;
      h_sync_off  <= '0;
      h_sync_on   <= '0;
      h_half      <= '0;
      ctrl        <= '0;
      pitch       <= '0;
      pan_x       <= '0;
      pan_y       <= '0;
      depth       <= '0;
    end else if (we) begin
      case (addr)
        A_V_WIN_STOP:  v_win_stop  <= d;
        A_V_BLANK_ON:  v_blank_on  <= d;
        A_V_BLANK_OFF: v_blank_off <= d;
        A_V_WIN_START: v_win_start <= d;
        A_V_SYNC_OFF:  v_sync_off  <= d;
        A_V_SYNC_ON:   v_sync_on   <= d;
        A_V_TOTAL:     v_total     <= d;
        A_H_FETCH:     h_fetch     <= d;
        A_H_TOTAL:     h_total     <= d;
        A_H_BLANK_ON:  h_blank_on  <= d;
        A_H_BLANK_OFF: h_blank_off <= d;
        A_H_SYNC_OFF:  h_sync_off  <= d;
        A_H_SYNC_ON:   h_sync_on   <= d;
        A_H_HALF:      h_half      <= d;
        A_CTRL: begin
          ctrl.force_blank <= wdata[BLANK_BIT];
          ctrl.vs_en       <= &wdata[VS_EN_LO +: 2];
          ctrl.hs_en       <= &wdata[HS_EN_LO +: 2];
        end
        A_PITCH: pitch <= wdata[AW-1:0];
        A_PAN: begin
          pan_x <= wdata[15:0];
          pan_y <= wdata[31:16];
        end
        A_DEPTH: depth <= wdata[1:0];
        default: ;
      endcase
    end
  end

  // pending start address, recomputed continuously from the shadow fields
  logic [PW-1:0] prod;
  logic [AW-1:0] xbytes, lin, pend;

  always_comb begin
    prod   = {{AW{1'b0}}, pan_y} * {16'b0, pitch};
    xbytes = AW'(pan_x) << depth;
    lin    = prod[AW-1:0] + xbytes;
    pend   = {lin[AW-1:ALIGN], {ALIGN{1'b0}}};
  end

  wire unused_prod = &{1'b0, prod[PW-1:AW], lin[ALIGN-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fb_start <= '0;
    else if (blank_go) fb_start <= pend;
  end

endmodule

// File: rtl/rtg_hgen.sv
module rtg_hgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_half,
  input  logic [CW-1:0] h_fetch,
  input  logic [CW-1:0] h_blank_on,
  input  logic [CW-1:0] h_blank_off,
  input  logic [CW-1:0] h_sync_on,
  input  logic [CW-1:0] h_sync_off,
  output logic [CW-1:0] hcnt,
  output logic          line_end,
  output logic          half_pt,
  output logic          fetch_pt,
  output logic          h_act,
  output logic          h_sync_raw
);

  localparam logic [CW:0]   ONE_X = (CW+1)'(1);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW:0] lim;
  assign lim      = {1'b0, h_total} + ONE_X;
  assign line_end = {1'b0, hcnt} >= lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + ONE;
  end

  assign half_pt    = (hcnt == h_half);
  assign fetch_pt   = (hcnt == h_fetch);
  assign h_act      = (hcnt >= h_blank_off) && (hcnt < h_blank_on);
  assign h_sync_raw = (hcnt >= h_sync_on) || (hcnt < h_sync_off);

endmodule

// File: rtl/rtg_vgen.sv
module rtg_vgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          half_pt,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_blank_on,
  input  logic [CW-1:0] v_blank_off,
  input  logic [CW-1:0] v_sync_on,
  input  logic [CW-1:0] v_sync_off,
  input  logic [CW-1:0] v_win_start,
  input  logic [CW-1:0] v_win_stop,
  output logic [CW-1:0] vcnt,
  output logic          blank_go,
  output logic          v_act,
  output logic          v_sync_raw,
  output logic          v_win
);

  localparam logic [CW:0]   ONE_X = (CW+1)'(1);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          step, last;
  logic [CW-1:0] nxt;

  assign step     = line_end | half_pt;
  assign last     = ({1'b0, vcnt} + ONE_X) >= {1'b0, v_total};
  assign nxt      = last ? '0 : vcnt + ONE;
  assign blank_go = step && (nxt == v_blank_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vcnt <= '0;
    else if (step) vcnt <= nxt;
  end

  assign v_act      = (vcnt >= v_blank_off) && (vcnt < v_blank_on);
  assign v_sync_raw = (vcnt >= v_sync_on) || (vcnt < v_sync_off);
  assign v_win      = (vcnt >= v_win_start) && (vcnt < v_win_stop);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW    = 12,
  parameter int AW    = 24,
  parameter int ALIGN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              vwin,
  output logic              fetch_go,
  output logic [AW-1:0]     fb_start
);

  logic [CW-1:0] v_win_stop, v_blank_on, v_blank_off, v_win_start;
  logic [CW-1:0] v_sync_off, v_sync_on, v_total;
  logic [CW-1:0] h_fetch, h_total, h_blank_on, h_blank_off;
  logic [CW-1:0] h_sync_off, h_sync_on, h_half;
  ctrl_t         ctrl_q;
  logic [CW-1:0] hcnt, vcnt;
  logic          line_end, half_pt, fetch_pt, h_act, h_sync_raw;
  logic          blank_go, v_act, v_sync_raw, v_win;

  rtg_regs #(.CW(CW), .AW(AW), .ALIGN(ALIGN)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .blank_go    (blank_go),
    .v_win_stop  (v_win_stop),
    .v_blank_on  (v_blank_on),
    .v_blank_off (v_blank_off),
    .v_win_start (v_win_start),
    .v_sync_off  (v_sync_off),
    .v_sync_on   (v_sync_on),
    .v_total     (v_total),
    .h_fetch     (h_fetch),
    .h_total     (h_total),
    .h_blank_on  (h_blank_on),
    .h_blank_off (h_blank_off),
    .h_sync_off  (h_sync_off),
    .h_sync_on   (h_sync_on),
    .h_half      (h_half),
    .ctrl        (ctrl_q),
    .fb_start    (fb_start)
  );

  rtg_hgen #(.CW(CW)) u_hgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_total     (h_total),
    .h_half      (h_half),
    .h_fetch     (h_fetch),
    .h_blank_on  (h_blank_on),
    .h_blank_off (h_blank_off),
    .h_sync_on   (h_sync_on),
    .h_sync_off  (h_sync_off),
    .hcnt        (hcnt),
    .line_end    (line_end),
    .half_pt     (half_pt),
    .fetch_pt    (fetch_pt),
    .h_act       (h_act),
    .h_sync_raw  (h_sync_raw)
  );

  rtg_vgen #(.CW(CW)) u_vgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .half_pt     (half_pt),
    .v_total     (v_total),
    .v_blank_on  (v_blank_on),
    .v_blank_off (v_blank_off),
    .v_sync_on   (v_sync_on),
    .v_sync_off  (v_sync_off),
    .v_win_start (v_win_start),
    .v_win_stop  (v_win_stop),
    .vcnt        (vcnt),
    .blank_go    (blank_go),
    .v_act       (v_act),
    .v_sync_raw  (v_sync_raw),
    .v_win       (v_win)
  );

  // output stage: one register so every pin leaves a flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      de       <= 1'b0;
      vwin     <= 1'b0;
      fetch_go <= 1'b0;
    end else begin
      hsync    <= h_sync_raw & ctrl_q.hs_en;
      vsync    <= v_sync_raw & ctrl_q.vs_en;
      de       <= h_act & v_act & ~ctrl_q.force_blank;
      vwin     <= v_win;
      fetch_go <= fetch_pt & v_act;
    end
  end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] h_total,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] v_blank_on,
  input ctrl_t         ctrl_q,
  input logic          de,
  input logic          hsync,
  input logic          vsync,
  input logic [AW-1:0] fb_start
);

  logic [CW:0] hlim;
  assign hlim = {1'b0, h_total} + (CW+1)'(1);

  assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, hcnt} >= hlim) |=> (hcnt == '0));

  assert_hstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, hcnt} < hlim) |=> (hcnt == $past(hcnt) + CW'(1)));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.force_blank |=> !de);

  assert_vsync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.vs_en |=> !vsync);

  assert_hsync_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.hs_en |=> !hsync);

  assert_start_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_start) |-> (vcnt == v_blank_on));

endmodule

bind raster_timing_gen raster_timing_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hcnt       (hcnt),
  .h_total    (h_total),
  .vcnt       (vcnt),
  .v_blank_on (v_blank_on),
  .ctrl_q     (ctrl_q),
  .de         (de),
  .hsync      (hsync),
  .vsync      (vsync),
  .fb_start   (fb_start)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          hsync, vsync, de, vwin, fetch_go;
  logic [AW-1:0] fb_start;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  raster_timing_gen #(.CW(12), .AW(AW), .ALIGN(5)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .vwin(vwin), .fetch_go(fetch_go), .fb_start(fb_start)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // driver side: queue the expected value with its requirement tag
  task automatic expect_item(input string tag, input int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic score(input int actual);
    string t;
    int    e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R13 scoreboard empty: actual %0d expected none", actual);
    end else begin
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      if (actual != e) begin
        errors++;
        $display("FAIL %s: actual %0d expected %0d", t, actual, e);
      end
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0:       return hsync;
      1:       return vsync;
      default: return de;
    endcase
  endfunction

  task automatic wait_rise(input int sel);
    logic p, c;
    p = sig(sel);
    forever begin
      @(negedge clk);
      c = sig(sel);
      if (!p && c) break;
      p = c;
    end
  endtask

  task automatic wait_fall(input int sel);
    logic p, c;
    p = sig(sel);
    forever begin
      @(negedge clk);
      c = sig(sel);
      if (p && !c) break;
      p = c;
    end
  endtask

  task automatic period(input int sel, output int n);
    logic p, c;
    wait_rise(sel);
    n = 0;
    p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      c = sig(sel);
      if (!p && c) break;
      p = c;
    end
  endtask

  // counts over any whole frame are independent of the starting phase
  task automatic frame_counts(input string ctx, input int f,
                              input int e_hs, input int e_vs, input int e_de,
                              input int e_win, input int e_fe);
    int hs, vs, dc, wc, fc;
    expect_item({"R2 hsync per frame ", ctx}, e_hs);
    expect_item({"R3 vsync per frame ", ctx}, e_vs);
    expect_item({"R4 de per frame ", ctx}, e_de);
    expect_item({"R5 vwin per frame ", ctx}, e_win);
    expect_item({"R6 fetch per frame ", ctx}, e_fe);
    hs = 0; vs = 0; dc = 0; wc = 0; fc = 0;
    for (int i = 0; i < f; i++) begin
      @(negedge clk);
      hs += int'(hsync); vs += int'(vsync); dc += int'(de);
      wc += int'(vwin);  fc += int'(fetch_go);
    end
    score(hs); score(vs); score(dc); score(wc); score(fc);
  endtask

  task automatic program_vertical();
    wr(5'd6, 32'd16);  // total half-lines: 8 lines
    wr(5'd5, 32'd14);  // sync on
    wr(5'd4, 32'd2);   // sync off
    wr(5'd2, 32'd4);   // blank off
    wr(5'd1, 32'd12);  // blank on
    wr(5'd3, 32'd3);   // window start
    wr(5'd0, 32'd13);  // window stop
  endtask

  task automatic program_mode_a();
    wr(5'd8,  32'd10); // line = 12 clocks
    wr(5'd12, 32'd11);
    wr(5'd11, 32'd1);
    wr(5'd10, 32'd3);
    wr(5'd9,  32'd9);
    wr(5'd14, 32'd6);
    wr(5'd7,  32'd2);
  endtask

  initial begin
    int n;
    // R13 reset state
    repeat (3) @(negedge clk);
    expect_item("R13 hsync at reset", 0);    score(int'(hsync));
    expect_item("R13 vsync at reset", 0);    score(int'(vsync));
    expect_item("R13 de at reset", 0);       score(int'(de));
    expect_item("R13 fb_start at reset", 0); score(int'(fb_start));
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    expect_item("R13 vsync with zero regs", 0); score(int'(vsync));
    expect_item("R13 de with zero regs", 0);    score(int'(de));

    // mode A: 12-clock lines, 8-line frame = 96 clocks
    program_vertical();
    program_mode_a();
    wr(5'd17, 32'd640);
    wr(5'd19, 32'd1);
    wr(5'd18, {16'd3, 16'd33});
    wr(5'd16, 32'h3b);
    repeat (200) @(negedge clk);
    frame_counts("mode A", 96, 16, 24, 24, 60, 4);
    period(0, n); expect_item("R1 line period mode A", 12);  score(n);
    period(1, n); expect_item("R3 frame period mode A", 96); score(n);
    expect_item("R10 start addr 3*640+(33<<1) aligned", 1984); score(int'(fb_start));

    // R11 deferral: write during active video
    wait_fall(1);
    wait_rise(2);
    wr(5'd17, 32'd256);
    wr(5'd19, 32'd2);
    wr(5'd18, {16'd2, 16'd8});
    expect_item("R11 start held during active video", 1984); score(int'(fb_start));
    wait_rise(1);
    expect_item("R11 start applied in blank (R10 2*256+32)", 544); score(int'(fb_start));

    // R7 forced blank: counters keep running
    wr(5'd16, 32'h43b);
    repeat (4) @(negedge clk);
    frame_counts("R7 forced blank", 96, 16, 24, 0, 60, 4);

    // R8 one vertical enable bit clear
    wr(5'd16, 32'h3a);
    repeat (4) @(negedge clk);
    frame_counts("R8 vsync pair partial", 96, 16, 0, 24, 60, 4);
    wr(5'd16, 32'h39);
    repeat (4) @(negedge clk);
    frame_counts("R8 vsync other bit clear", 96, 16, 0, 24, 60, 4);

    // R9 horizontal enable pair
    wr(5'd16, 32'h0b);
    repeat (4) @(negedge clk);
    frame_counts("R9 hsync pair clear", 96, 0, 24, 24, 60, 4);
    wr(5'd16, 32'h2b);
    repeat (4) @(negedge clk);
    frame_counts("R9 hsync pair partial", 96, 0, 24, 24, 60, 4);

    // R12 ignored slots
    wr(5'd16, 32'h3b);
    wr(5'd13, 32'd5);
    wr(5'd15, 32'd7);
    wr(5'd25, 32'd99);
    repeat (200) @(negedge clk);
    frame_counts("R12 after unused writes", 96, 16, 24, 24, 60, 4);
    period(0, n); expect_item("R12 line period unchanged", 12); score(n);

    // mode B: 16-clock lines, 128-clock frame
    wr(5'd8,  32'd14);
    wr(5'd12, 32'd15);
    wr(5'd11, 32'd2);
    wr(5'd10, 32'd4);
    wr(5'd9,  32'd12);
    wr(5'd14, 32'd8);
    wr(5'd7,  32'd3);
    repeat (300) @(negedge clk);
    frame_counts("mode B", 128, 24, 32, 32, 80, 4);
    period(0, n); expect_item("R1 line period mode B", 16);  score(n);
    period(1, n); expect_item("R3 frame period mode B", 128); score(n);

    // R10 depth code 0
    wr(5'd17, 32'd100);
    wr(5'd19, 32'd0);
    wr(5'd18, {16'd1, 16'd40});
    wait_rise(1);
    wait_rise(1);
    expect_item("R10 start addr 100+40 aligned", 128); score(int'(fb_start));

    summary();
    $finish;
  end

endmodule